// File: doc/BRIEF.md
# Colour Correction Matrix and RGB Tone Pipeline

This block takes a stream of three-component pixels straight from a colour extractor and turns them into display-ready RGB. A programmable 3×3 matrix first maps the sensor's colour space (either luma plus two colour differences, or raw R, G and B) into standard RGB. Loading the identity matrix passes monochrome data through unchanged. Each matrix output channel then goes through a fixed chain of steps. Red and blue get a white-balance gain, and green passes at unity. Each channel then gets its own signed black offset. A knee follows, which compresses values above a threshold with a programmable slope. Last comes a piecewise-linear gamma curve that produces 8-bit output. The knee settings and the gamma curve are shared by all three channels.

The pipeline accepts one pixel per cycle with no stall. Configuration goes through a simple write port, and each write takes effect on the next clock edge. Software is expected to change settings only between frames or while the pixel stream is idle. Every intermediate value is clipped to zero and to full scale after each stage, so no stage can wrap around.

Top module: `ctc_colour_pipe`

## Requirements
- R1: After reset, `rgb_valid` is 0 and all three outputs are 0. The configuration resets to:
  - identity matrix (coefficient 256 on the diagonal, 0 elsewhere);
  - gains of 256;
  - offsets of 0;
  - knee threshold 1023 and slope 256;
  - gamma point i equal to 16·i.
- R2: Each input pixel with `pix_valid` high produces exactly one output with `rgb_valid` high, exactly 5 clock cycles later. Input gaps appear unchanged at the output, and back-to-back pixels are accepted every cycle.
- R3: Matrix output channel r (0=R, 1=G, 2=B) is computed as clip((Σc coef[3r+c]·in_c + 128) >>> 8, 0, 1023). The coefficients are 10-bit two's complement with 8 fractional bits, `>>>` rounds toward minus infinity, and inputs c0, c1, c2 are unsigned 10-bit values.
- R4: Red becomes clip((R·gain_r + 128) >> 8, 0, 1023), and blue is treated the same way with gain_b. The gains are unsigned 10-bit values with 8 fractional bits. Green is not scaled.
- R5: After the gain, each channel adds its own 10-bit two's complement offset, and the result is clipped to 0..1023.
- R6: After the offset, a value x greater than the threshold T becomes clip(T + (((x − T)·S + 128) >> 8), 0, 1023), where S is the slope. A value x ≤ T passes unchanged.
- R7: Gamma takes i = x[9:6] and f = x[5:0] and outputs clip(P[i] + (((P[i+1] − P[i])·f + 32) >>> 6), 0, 255), where P[16] is fixed at 255 and the 16 points P[0..15] are 8-bit values.
- R8: One knee threshold, one slope and one gamma table are used for all three channels, so equal post-offset values give equal outputs.
- R9: While `rgb_valid` is low, `rgb_r`, `rgb_g` and `rgb_b` keep the value of the last valid output (0 after reset).
- R10: Write addresses are decoded in full:
  - 0–8 are coefficients in row-major order (row = output R, G, B);
  - 9 is gain_r and 10 is gain_b;
  - 11–13 are offsets R, G, B;
  - 14 is the threshold and 15 is the slope;
  - 16–31 are gamma points 0–15;
  - each field takes the low bits of `cfg_wdata`;
  - a slope write above 256 is stored as 256;
  - addresses 32–63 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration write address |
| cfg_wdata | input | 16 | Configuration write data |
| pix_valid | input | 1 | Input pixel valid |
| pix_c0 | input | 10 | Input component 0 (R or luma) |
| pix_c1 | input | 10 | Input component 1 (G or colour difference) |
| pix_c2 | input | 10 | Input component 2 (B or colour difference) |
| rgb_valid | output | 1 | Output pixel valid |
| rgb_r | output | 8 | Corrected red |
| rgb_g | output | 8 | Corrected green |
| rgb_b | output | 8 | Corrected blue |

## Verification
A corrupted configuration word or a badly rounded stage shows up at the RGB ports on the first pixel that exercises it, five cycles after that pixel enters. The error is often masked by later clipping or by the gamma curve, so the stimulus pushes each stage on its own into the range where its effect survives to the output. This includes saturation at both ends, the knee region and the top gamma segment. A broken valid pipeline shows at once as a gap or an extra pulse on `rgb_valid`, or as output data that moves while the valid signal is low.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
    // configuration address map
    localparam int A_COEF   = 0;
    localparam int N_COEF   = 9;
    localparam int A_GAIN_R = 9;
    localparam int A_GAIN_B = 10;
    localparam int A_OFF    = 11;
    localparam int A_THR    = 14;
    localparam int A_SLOPE  = 15;
    localparam int A_GAMMA  = 16;
    localparam int NCH      = 3;
endpackage

// File: rtl/ctc_regs.sv
module ctc_regs
    import ctc_pkg::*;
#(
    parameter int DW   = 10,
    parameter int CW   = 10,
    parameter int FRAC = 8,
    parameter int GW   = 10,
    parameter int OFW  = 10,
    parameter int SLW  = 9,
    parameter int OW   = 8,
    parameter int NSEG = 16,
    parameter int AW   = 6,
    parameter int RW   = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [AW-1:0]               addr,
    input  logic [RW-1:0]               wdata,
    output logic [N_COEF-1:0][CW-1:0]   coef,
    output logic [GW-1:0]               gain_r,
    output logic [GW-1:0]               gain_b,
    output logic [NCH-1:0][OFW-1:0]     off,
    output logic [DW-1:0]               thr,
    output logic [SLW-1:0]              slope,
    output logic [NSEG-1:0][OW-1:0]     gam
);
    localparam int UNITY = 1 << FRAC;

    typedef struct packed {
        logic [N_COEF-1:0][CW-1:0] coef;
        logic [GW-1:0]             gr;
        logic [GW-1:0]             gb;
        logic [NCH-1:0][OFW-1:0]   off;
        logic [DW-1:0]             thr;
        logic [SLW-1:0]            sl;
        logic [NSEG-1:0][OW-1:0]   gam;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    function automatic cfg_t reset_cfg();
        cfg_t c;
        c = '0;
        for (int i = 0; i < N_COEF; i++)
            c.coef[i] = ((i % 4) == 0) ? CW'(UNITY) : '0;
        c.gr  = GW'(UNITY);
        c.gb  = GW'(UNITY);
        c.thr = '1;
        c.sl  = SLW'(UNITY);
        for (int i = 0; i < NSEG; i++)
            c.gam[i] = OW'((i * (1 << OW)) / NSEG);
        return c;
    endfunction

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            for (int i = 0; i < N_COEF; i++)
                if (addr == AW'(A_COEF + i)) cfg_d.coef[i] = wdata[CW-1:0];
            if (addr == AW'(A_GAIN_R)) cfg_d.gr = wdata[GW-1:0];
            if (addr == AW'(A_GAIN_B)) cfg_d.gb = wdata[GW-1:0];
            for (int i = 0; i < NCH; i++)
                if (addr == AW'(A_OFF + i)) cfg_d.off[i] = wdata[OFW-1:0];
            if (addr == AW'(A_THR)) cfg_d.thr = wdata[DW-1:0];
            if (addr == AW'(A_SLOPE))
                cfg_d.sl = (wdata > RW'(UNITY)) ? SLW'(UNITY) : wdata[SLW-1:0];
            for (int i = 0; i < NSEG; i++)
                if (addr == AW'(A_GAMMA + i)) cfg_d.gam[i] = wdata[OW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= reset_cfg();
        else        cfg_q <= cfg_d;
    end

    assign coef   = cfg_q.coef;
    assign gain_r = cfg_q.gr;
    assign gain_b = cfg_q.gb;
    assign off    = cfg_q.off;
    assign thr    = cfg_q.thr;
    assign slope  = cfg_q.sl;
    assign gam    = cfg_q.gam;

    // R10
    slope_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.sl <= SLW'(UNITY));
endmodule

// File: rtl/ctc_matrix.sv
module ctc_matrix
    import ctc_pkg::*;
#(
    parameter int DW   = 10,
    parameter int CW   = 10,
    parameter int FRAC = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [NCH-1:0][DW-1:0]      in_pix,
    input  logic [N_COEF-1:0][CW-1:0]   coef,
    output logic                        out_valid,
    output logic [NCH-1:0][DW-1:0]      out_pix
);
    localparam int SW  = DW + CW + 3;
    localparam int RND = 1 << (FRAC - 1);

    typedef struct packed {
        logic                   v;
        logic [NCH-1:0][DW-1:0] pix;
    } mat_t;

    mat_t st_d, st_q;

    function automatic logic [DW-1:0] row_mac(
        input logic [NCH-1:0][DW-1:0] px,
        input logic [NCH-1:0][CW-1:0] cf
    );
        logic signed [SW-1:0] acc, xa, ca, sh;
        acc = '0;
        for (int c = 0; c < NCH; c++) begin
            xa  = $signed({{(SW-DW){1'b0}}, px[c]});
            ca  = $signed({{(SW-CW){cf[c][CW-1]}}, cf[c]});
            acc = acc + xa * ca;
        end
        acc = acc + SW'(RND);
        sh  = acc >>> FRAC;
        if (sh[SW-1])             return '0;
        else if (|sh[SW-2:DW])    return '1;
        else                      return sh[DW-1:0];
    endfunction

    always_comb begin
        st_d   = st_q;
        st_d.v = in_valid;
        if (in_valid) begin
            for (int r = 0; r < NCH; r++)
                st_d.pix[r] = row_mac(in_pix, coef[r*NCH +: NCH]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.v;
    assign out_pix   = st_q.pix;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    gap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

// File: rtl/ctc_tone.sv
module ctc_tone
    import ctc_pkg::*;
#(
    parameter int DW   = 10,
    parameter int GW   = 10,
    parameter int OFW  = 10,
    parameter int SLW  = 9,
    parameter int FRAC = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [NCH-1:0][DW-1:0]      in_pix,
    input  logic [GW-1:0]               gain_r,
    input  logic [GW-1:0]               gain_b,
    input  logic [NCH-1:0][OFW-1:0]     off,
    input  logic [DW-1:0]               thr,
    input  logic [SLW-1:0]              slope,
    output logic                        out_valid,
    output logic [NCH-1:0][DW-1:0]      out_pix
);
    localparam int RND = 1 << (FRAC - 1);
    localparam int PGW = DW + GW + 1;
    localparam int PKW = DW + SLW + 1;

    typedef struct packed {
        logic                   v1, v2, v3;
        logic [NCH-1:0][DW-1:0] gn;   // after gain
        logic [NCH-1:0][DW-1:0] of;   // after offset
        logic [NCH-1:0][DW-1:0] kn;   // after knee
    } tone_t;

    tone_t st_d, st_q;

    function automatic logic [DW-1:0] f_gain(input logic [DW-1:0] x, input logic [GW-1:0] g);
        logic [PGW-1:0] p;
        p = PGW'(x) * PGW'(g) + PGW'(RND);
        p = p >> FRAC;
        if (|p[PGW-1:DW]) return '1;
        else              return p[DW-1:0];
    endfunction

    function automatic logic [DW-1:0] f_off(input logic [DW-1:0] x, input logic [OFW-1:0] o);
        logic signed [DW+1:0] s;
        s = $signed({2'b00, x}) + $signed(o);
        if (s[DW+1])      return '0;
        else if (s[DW])   return '1;
        else              return s[DW-1:0];
    endfunction

    function automatic logic [DW-1:0] f_knee(input logic [DW-1:0] x, input logic [DW-1:0] t,
                                             input logic [SLW-1:0] s);
        logic [PKW-1:0] p;
        if (x <= t) return x;
        p = PKW'(x - t) * PKW'(s) + PKW'(RND);
        p = (p >> FRAC) + PKW'(t);
        if (|p[PKW-1:DW]) return '1;
        else              return p[DW-1:0];
    endfunction

    always_comb begin
        st_d    = st_q;
        st_d.v1 = in_valid;
        st_d.v2 = st_q.v1;
        st_d.v3 = st_q.v2;
        for (int i = 0; i < NCH; i++) begin
            if (in_valid) begin
                if (i == 0)      st_d.gn[i] = f_gain(in_pix[i], gain_r);
                else if (i == 2) st_d.gn[i] = f_gain(in_pix[i], gain_b);
                else             st_d.gn[i] = in_pix[i];
            end
            if (st_q.v1) st_d.of[i] = f_off(st_q.gn[i], off[i]);
            if (st_q.v2) st_d.kn[i] = f_knee(st_q.of[i], thr, slope);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.v3;
    assign out_pix   = st_q.kn;

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R6
        knee_no_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.v2 |=> st_q.kn[i] <= $past(st_q.of[i]));
    end
endmodule

// File: rtl/ctc_gamma_lane.sv
module ctc_gamma_lane #(
    parameter int DW   = 10,
    parameter int OW   = 8,
    parameter int NSEG = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [DW-1:0]             x,
    input  logic [NSEG-1:0][OW-1:0]   tab,
    output logic [OW-1:0]             y
);
    localparam int SB  = $clog2(NSEG);
    localparam int FB  = DW - SB;
    localparam int W   = OW + FB + 3;
    localparam int RND = 1 << (FB - 1);

    typedef struct packed {
        logic [OW-1:0] y;
    } gam_t;

    gam_t st_d, st_q;

    function automatic logic [OW-1:0] interp(input logic [DW-1:0] v,
                                             input logic [NSEG-1:0][OW-1:0] t);
        logic [SB-1:0]       idx, nidx;
        logic [OW-1:0]       p0, p1;
        logic signed [W-1:0] a, b, fe, r;
        idx  = v[DW-1 -: SB];
        nidx = idx + 1'b1;
        p0   = t[idx];
        p1   = (idx == SB'(NSEG - 1)) ? '1 : t[nidx];
        a    = $signed({{(W-OW){1'b0}}, p0});
        b    = $signed({{(W-OW){1'b0}}, p1});
        fe   = $signed({{(W-FB){1'b0}}, v[FB-1:0]});
        r    = ((b - a) * fe + W'(RND)) >>> FB;
        r    = a + r;
        if (r[W-1])            return '0;
        else if (|r[W-2:OW])   return '1;
        else                   return r[OW-1:0];
    endfunction

    always_comb begin
        st_d = st_q;
        if (in_valid) st_d.y = interp(x, tab);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign y = st_q.y;
endmodule

// File: rtl/ctc_colour_pipe.sv
module ctc_colour_pipe
    import ctc_pkg::*;
#(
    parameter int DW   = 10,
    parameter int CW   = 10,
    parameter int FRAC = 8,
    parameter int GW   = 10,
    parameter int OFW  = 10,
    parameter int SLW  = 9,
    parameter int OW   = 8,
    parameter int NSEG = 16,
    parameter int AW   = 6,
    parameter int RW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [RW-1:0]   cfg_wdata,
    input  logic            pix_valid,
    input  logic [DW-1:0]   pix_c0,
    input  logic [DW-1:0]   pix_c1,
    input  logic [DW-1:0]   pix_c2,
    output logic            rgb_valid,
    output logic [OW-1:0]   rgb_r,
    output logic [OW-1:0]   rgb_g,
    output logic [OW-1:0]   rgb_b
);
    logic [N_COEF-1:0][CW-1:0] coef;
    logic [GW-1:0]             gain_r, gain_b;
    logic [NCH-1:0][OFW-1:0]   off;
    logic [DW-1:0]             thr;
    logic [SLW-1:0]            slope;
    logic [NSEG-1:0][OW-1:0]   gam;

    logic                      mat_v, tone_v;
    logic [NCH-1:0][DW-1:0]    mat_pix, tone_pix;
    logic [NCH-1:0][OW-1:0]    gy;
    logic                      rgb_valid_d, rgb_valid_q;

    ctc_regs #(.DW(DW), .CW(CW), .FRAC(FRAC), .GW(GW), .OFW(OFW), .SLW(SLW),
               .OW(OW), .NSEG(NSEG), .AW(AW), .RW(RW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .coef(coef), .gain_r(gain_r), .gain_b(gain_b), .off(off), .thr(thr),
        .slope(slope), .gam(gam)
    );

    ctc_matrix #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_matrix (
        .clk(clk), .rst_n(rst_n), .in_valid(pix_valid),
        .in_pix({pix_c2, pix_c1, pix_c0}), .coef(coef),
        .out_valid(mat_v), .out_pix(mat_pix)
    );

    ctc_tone #(.DW(DW), .GW(GW), .OFW(OFW), .SLW(SLW), .FRAC(FRAC)) u_tone (
        .clk(clk), .rst_n(rst_n), .in_valid(mat_v), .in_pix(mat_pix),
        .gain_r(gain_r), .gain_b(gain_b), .off(off), .thr(thr), .slope(slope),
        .out_valid(tone_v), .out_pix(tone_pix)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_gamma
        ctc_gamma_lane #(.DW(DW), .OW(OW), .NSEG(NSEG)) u_lane (
            .clk(clk), .rst_n(rst_n), .in_valid(tone_v), .x(tone_pix[i]),
            .tab(gam), .y(gy[i])
        );
    end

    always_comb rgb_valid_d = tone_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rgb_valid_q <= 1'b0;
        else        rgb_valid_q <= rgb_valid_d;
    end

    assign rgb_valid = rgb_valid_q;
    assign rgb_r     = gy[0];
    assign rgb_g     = gy[1];
    assign rgb_b     = gy[2];

    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tone_v |=> (!rgb_valid && $stable({rgb_r, rgb_g, rgb_b})));
endmodule

// File: tb/ctc_colour_pipe_test.sv
module ctc_colour_pipe_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [5:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic        pix_valid;
    logic [9:0]  pix_c0, pix_c1, pix_c2;
    logic        rgb_valid;
    logic [7:0]  rgb_r, rgb_g, rgb_b;

    always #5 clk = ~clk;

    ctc_colour_pipe uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_c0(pix_c0),
        .pix_c1(pix_c1), .pix_c2(pix_c2), .rgb_valid(rgb_valid),
        .rgb_r(rgb_r), .rgb_g(rgb_g), .rgb_b(rgb_b)
    );

    int n_tests = 0, n_fail = 0;
    // configuration as the bench believes it to be
    int sc[9], sgr, sgb, so[3], sthr, ssl, sgam[16];
    // stimulus arrays
    int a0[64], a1[64], a2[64];
    bit vv[64];
    int lr = 0, lg = 0, lb = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clipi(int v, int hi);
        return (v < 0) ? 0 : ((v > hi) ? hi : v);
    endfunction

    function automatic int chain(int x, int ch);
        int idx, f, y0, y1;
        if (ch == 0) x = clipi((x * sgr + 128) >>> 8, 1023);
        if (ch == 2) x = clipi((x * sgb + 128) >>> 8, 1023);
        x = clipi(x + so[ch], 1023);
        if (x > sthr) x = clipi(sthr + (((x - sthr) * ssl + 128) >>> 8), 1023);
        idx = x >>> 6;
        f   = x & 63;
        y0  = sgam[idx];
        y1  = (idx == 15) ? 255 : sgam[idx + 1];
        return clipi(y0 + (((y1 - y0) * f + 32) >>> 6), 255);
    endfunction

    function automatic int model(int ch, int c0, int c1, int c2);
        int m;
        m = clipi((sc[ch*3] * c0 + sc[ch*3+1] * c1 + sc[ch*3+2] * c2 + 128) >>> 8, 1023);
        return chain(m, ch);
    endfunction

    task automatic cfg(int addr, int data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 6'(addr);
        cfg_wdata = 16'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < 9) sc[addr] = data;
        else if (addr == 9) sgr = data;
        else if (addr == 10) sgb = data;
        else if (addr >= 11 && addr <= 13) so[addr-11] = data;
        else if (addr == 14) sthr = data;
        else if (addr == 15) ssl = (data > 256) ? 256 : data;
        else if (addr >= 16 && addr <= 31) sgam[addr-16] = data;
    endtask

    task automatic setpx(int i, bit v, int c0, int c1, int c2);
        vv[i] = v; a0[i] = c0; a1[i] = c1; a2[i] = c2;
    endtask

    // drive n entries, check each output 5 cycles later, hold during gaps
    task automatic run(int n, string req);
        int er, eg, eb;
        for (int c = 0; c < n + 5; c++) begin
            @(negedge clk);
            if (c >= 5) begin
                if (vv[c-5]) begin
                    er = model(0, a0[c-5], a1[c-5], a2[c-5]);
                    eg = model(1, a0[c-5], a1[c-5], a2[c-5]);
                    eb = model(2, a0[c-5], a1[c-5], a2[c-5]);
                    check(rgb_valid == 1'b1, "R2", "valid", int'(rgb_valid), 1);
                    check(int'(rgb_r) == er, req, "red", int'(rgb_r), er);
                    check(int'(rgb_g) == eg, req, "green", int'(rgb_g), eg);
                    check(int'(rgb_b) == eb, req, "blue", int'(rgb_b), eb);
                    lr = er; lg = eg; lb = eb;
                end else begin
                    check(rgb_valid == 1'b0, "R2", "valid gap", int'(rgb_valid), 0);
                    check(int'(rgb_r) == lr && int'(rgb_g) == lg && int'(rgb_b) == lb,
                          "R9", "hold red", int'(rgb_r), lr);
                end
            end
            if (c < n) begin
                pix_valid = vv[c];
                pix_c0 = 10'(a0[c]); pix_c1 = 10'(a1[c]); pix_c2 = 10'(a2[c]);
            end else begin
                pix_valid = 1'b0;
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        pix_valid = 1'b0; pix_c0 = '0; pix_c1 = '0; pix_c2 = '0;
        for (int i = 0; i < 9; i++) sc[i] = (i % 4 == 0) ? 256 : 0;
        sgr = 256; sgb = 256; so[0] = 0; so[1] = 0; so[2] = 0;
        sthr = 1023; ssl = 256;
        for (int i = 0; i < 16; i++) sgam[i] = 16 * i;
        repeat (3) @(negedge clk);
        check(rgb_valid == 1'b0, "R1", "valid in reset", int'(rgb_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rgb_valid == 1'b0, "R1", "valid after reset", int'(rgb_valid), 0);
        check({rgb_r, rgb_g, rgb_b} == 24'd0, "R1", "rgb after reset", int'(rgb_r), 0);
    endtask

    task automatic t_default();   // R1 default configuration path
        setpx(0, 1, 400, 100, 1023);
        setpx(1, 1, 0, 0, 0);
        setpx(2, 1, 64, 640, 1000);
        setpx(3, 1, 1023, 1023, 1023);
        run(4, "R1");
    endtask

    task automatic t_matrix();    // R3
        cfg(0, 384); cfg(1, -128); cfg(2, 0);
        cfg(3, -64); cfg(4, 320);  cfg(5, 0);
        cfg(6, 0);   cfg(7, -256); cfg(8, 511);
        setpx(0, 1, 1000, 0, 0);
        setpx(1, 1, 0, 1000, 0);
        setpx(2, 1, 300, 200, 100);
        setpx(3, 1, 3, 5, 7);
        setpx(4, 1, 512, 511, 1023);
        run(5, "R3");
        for (int i = 0; i < 9; i++) cfg(i, (i % 4 == 0) ? 256 : 0);
    endtask

    task automatic t_gain();      // R4
        cfg(9, 512); cfg(10, 128);
        setpx(0, 1, 300, 300, 300);
        setpx(1, 1, 700, 700, 700);
        setpx(2, 1, 1, 1, 1);
        run(3, "R4");
        cfg(9, 256); cfg(10, 256);
    endtask

    task automatic t_offset();    // R5
        cfg(11, -100); cfg(12, 50); cfg(13, -512);
        setpx(0, 1, 50, 1000, 600);
        setpx(1, 1, 500, 500, 500);
        setpx(2, 1, 1023, 0, 1023);
        run(3, "R5");
        cfg(11, 511); cfg(12, 0); cfg(13, 0);
        setpx(0, 1, 600, 7, 9);
        run(1, "R5");
        cfg(11, 0);
    endtask

    task automatic t_knee();      // R6 R8
        cfg(14, 512); cfg(15, 64);
        setpx(0, 1, 100, 600, 1023);
        setpx(1, 1, 512, 513, 511);
        setpx(2, 1, 800, 800, 800);
        run(3, "R6");
        check(rgb_r == rgb_g && rgb_g == rgb_b, "R8", "shared knee/gamma", int'(rgb_g), int'(rgb_r));
    endtask

    task automatic t_gamma();     // R7
        for (int i = 0; i < 16; i++) cfg(16 + i, (i == 8) ? 20 : i * i);
        setpx(0, 1, 448, 460, 500);
        setpx(1, 1, 960, 1000, 1023);
        setpx(2, 1, 64, 100, 127);
        setpx(3, 1, 520, 559, 575);
        run(4, "R7");
    endtask

    task automatic t_stream();    // R2 R9
        for (int i = 0; i < 40; i++)
            setpx(i, (i % 7 != 3) && (i % 11 != 5), (i * 37) % 1024, (i * 91 + 5) % 1024,
                  (1023 - i * 23) % 1024);
        run(40, "R2");
    endtask

    task automatic t_regs();      // R10
        cfg(14, 512);
        cfg(15, 400);
        setpx(0, 1, 900, 700, 300);
        run(1, "R10");
        cfg(40, 0);
        cfg(47, 0);
        setpx(0, 1, 900, 700, 1000);
        setpx(1, 0, 0, 0, 0);
        setpx(2, 1, 50, 600, 1010);
        run(3, "R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_default();
        t_matrix();
        t_gain();
        t_offset();
        t_knee();
        t_gamma();
        t_stream();
        t_regs();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule